// File: doc/BRIEF.md
# Two-Way LRU Read Cache

This block is a small read-only cache placed between a processor load port and a slower main memory that returns one 32-bit word per request. It holds eight one-word lines arranged as four sets of two ways. Each byte address is split into a tag, a set index and a byte offset. The block compares the tags of both ways of the selected set in parallel. On a hit it returns the matching word. On a miss it fetches the word from memory, stores it in the set, and then returns it.

Each set keeps one replacement bit that names its least recently used way. The bit is updated on every hit and on every fill. When a set is full, the way named by that bit is the one overwritten. The processor pulses a request and waits for a one-cycle ready strobe. Hits complete in one cycle. Misses complete one cycle after memory answers.

Top module: `lru_read_cache`

## Requirements
- R1: Lookup uses tag = addr_i[31:4] and set = addr_i[3:2]. Bits addr_i[1:0] do not take part, so any offset returns the word at the address with those bits cleared.
- R2: A way hits when its line is valid and its stored tag equals the address tag. On a hit, rdata_o carries that way's stored word.
- R3: For a given address, at most one way of a set ever hits.
- R4: Each set's replacement bit is set to 1 (way 1 least recent) when way 0 is hit or filled. It is set to 0 when way 1 is hit or filled.
- R5: When req_i is accepted and hits, ready_o and hit_o are high in the next cycle with the data, and mem_req_o stays low.
- R6: When req_i is accepted and misses, mem_req_o goes high in the next cycle with mem_addr_o = addr_i[31:2]. Both stay unchanged until mem_ready_i. In the cycle after mem_ready_i, ready_o and miss_o are high and rdata_o equals mem_rdata_i.
- R7: On a miss, the fill goes to an invalid way first, with way 0 preferred when both ways are invalid. If both ways are valid, the fill goes to the way named by the replacement bit.
- R8: A req_i presented while a fill is outstanding is ignored. It produces no ready strobe and changes neither the memory request nor the cache contents.
- R9: Reset (rst_ni low) clears all valid bits and replacement bits and drives ready_o, hit_o, miss_o and mem_req_o low.
- R10: ready_o is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Load request pulse |
| addr_i | input | 32 | Byte address of the load |
| rdata_o | output | 32 | Returned word |
| ready_o | output | 1 | One-cycle completion strobe |
| hit_o | output | 1 | Completion was a hit |
| miss_o | output | 1 | Completion was a miss fill |
| mem_req_o | output | 1 | Memory fetch request, held until answered |
| mem_addr_o | output | 30 | Word address of the fetch |
| mem_rdata_i | input | 32 | Word returned by memory |
| mem_ready_i | input | 1 | Memory data valid strobe |

## Verification
The hardest situation to reach is eviction in a full set after the replacement bit has been changed by a hit rather than a fill. It only shows up as a later hit or miss on a specific address. The bench runs a directed sequence of three tags in one set, with a re-hit of the first tag between fills. It then runs a long pseudo-random sweep over four tags per set against a bench-side model of valid bits, tags and replacement bits. Stray requests are injected during fills of varying memory latency.

// File: rtl/lru_cache_pkg.sv
package lru_cache_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/lru_cache_way.sv
module lru_cache_way #(
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32,
  parameter int SET_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[set_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[set_i]  <= tag_i;
      data_q[set_i] <= wr_data_i;
    end
  end

  assign valid_o = valid_q[set_i];
  assign hit_o   = valid_q[set_i] && (tag_q[set_i] == tag_i);
  assign data_o  = data_q[set_i];

  p_fill_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(set_i)]);
endmodule

// File: rtl/lru_cache_repl.sv
module lru_cache_repl #(
  parameter int SET_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             upd_i,
  input  logic             way_i,
  output logic             lru_o
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] lru_q;

  // bit names the least recently used way
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lru_q <= '0;
    else if (upd_i) lru_q[set_i] <= ~way_i;
  end

  assign lru_o = lru_q[set_i];

  p_lru_way0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !way_i) |=> lru_q[$past(set_i)]);
  p_lru_way1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && way_i) |=> !lru_q[$past(set_i)]);
endmodule

// File: rtl/lru_cache_ctrl.sv
module lru_cache_ctrl
  import lru_cache_pkg::*;
#(
  parameter int WA_W   = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [WA_W-1:0]   waddr_i,
  input  logic              hit_i,
  input  logic              hit_way_i,
  input  logic [DATA_W-1:0] hit_data_i,
  input  logic              valid0_i,
  input  logic              valid1_i,
  input  logic              lru_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [WA_W-1:0]   look_addr_o,
  output logic              upd_o,
  output logic              upd_way_o,
  output logic              fill_o,
  output logic              mem_req_o,
  output logic [WA_W-1:0]   mem_addr_o,
  output logic              ready_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_state_e state_q, state_d;
  logic [WA_W-1:0] addr_q;
  logic accept, hit_acc, victim;

  assign accept  = (state_q == ST_IDLE) && req_i;
  assign hit_acc = accept && hit_i;
  assign fill_o  = (state_q == ST_FILL) && mem_ready_i;
  // invalid way first, way 0 preferred, else the LRU way
  assign victim  = !valid0_i ? 1'b0 : (!valid1_i ? 1'b1 : lru_i);

  assign upd_o       = hit_acc || fill_o;
  assign upd_way_o   = fill_o ? victim : hit_way_i;
  assign look_addr_o = (state_q == ST_IDLE) ? waddr_i : addr_q;
  assign mem_req_o   = (state_q == ST_FILL);
  assign mem_addr_o  = addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && !hit_i) state_d = ST_FILL;
      ST_FILL: if (mem_ready_i)      state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ready_o <= 1'b0;
      hit_o   <= 1'b0;
      miss_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      state_q <= state_d;
      if (accept) addr_q <= waddr_i;
      ready_o <= hit_acc || fill_o;
      hit_o   <= hit_acc;
      miss_o  <= fill_o;
      if (fill_o)       rdata_o <= mem_rdata_i;
      else if (hit_acc) rdata_o <= hit_data_i;
    end
  end

  p_hit_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_acc |=> (ready_o && hit_o && !mem_req_o));
  p_fill_resp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |=> (ready_o && miss_o && rdata_o == $past(mem_rdata_i)));
  p_mem_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_ignore_in_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> !ready_o);
  p_ready_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: rtl/lru_read_cache.sv
module lru_read_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SET_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              mem_req_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int TAG_W = WA_W - SET_W;
  localparam int WAYS  = 2;

  logic [WA_W-1:0]   look_addr;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag;
  logic [WAYS-1:0]   way_hit, way_valid;
  logic [DATA_W-1:0] way_data [WAYS];
  logic [DATA_W-1:0] hit_data;
  logic upd, upd_way, fill, lru;

  assign set_idx  = look_addr[SET_W-1:0];
  assign tag      = look_addr[WA_W-1:SET_W];
  assign hit_data = way_hit[1] ? way_data[1] : way_data[0];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    lru_cache_way #(.TAG_W(TAG_W), .DATA_W(DATA_W), .SET_W(SET_W)) u_way (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_idx),
      .tag_i     (tag),
      .wr_en_i   (fill && (upd_way == 1'(g))),
      .wr_data_i (mem_rdata_i),
      .valid_o   (way_valid[g]),
      .hit_o     (way_hit[g]),
      .data_o    (way_data[g])
    );
  end

  lru_cache_repl #(.SET_W(SET_W)) u_repl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_idx),
    .upd_i  (upd),
    .way_i  (upd_way),
    .lru_o  (lru)
  );

  lru_cache_ctrl #(.WA_W(WA_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .waddr_i     (addr_i[ADDR_W-1:2]),
    .hit_i       (|way_hit),
    .hit_way_i   (way_hit[1]),
    .hit_data_i  (hit_data),
    .valid0_i    (way_valid[0]),
    .valid1_i    (way_valid[1]),
    .lru_i       (lru),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .look_addr_o (look_addr),
    .upd_o       (upd),
    .upd_way_o   (upd_way),
    .fill_o      (fill),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .ready_o     (ready_o),
    .hit_o       (hit_o),
    .miss_o      (miss_o),
    .rdata_o     (rdata_o)
  );

  p_one_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit));
  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!ready_o && !mem_req_o));
endmodule

// File: tb/lru_read_cache_test.sv
`timescale 1ns/1ps
module lru_read_cache_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] rdata;
  logic        ready, hit, miss, mem_req;
  logic [29:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  bit          mv  [2][4];
  logic [27:0] mt  [2][4];
  logic [31:0] md  [2][4];
  bit          mlru[4];

  always #2.5 clk = ~clk;

  lru_read_cache uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr),
    .rdata_o(rdata), .ready_o(ready), .hit_o(hit), .miss_o(miss),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  function automatic logic [31:0] mem_fn(input logic [29:0] wa);
    return {wa, 2'b00} * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++) mv[w][s] = 0;
    for (int s = 0; s < 4; s++) mlru[s] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ready && !hit && !miss && !mem_req, "R9 outputs in reset",
        {28'b0, ready, hit, miss, mem_req}, 32'h0);
    rst_ni = 1'b1;
    clear_model();
  endtask

  task automatic do_access(input logic [31:0] a, input int lat, input bit stray, output bit got_hit);
    int s, w, v;
    logic [27:0] tg;
    logic [31:0] exp;
    bit eh;
    s  = int'(a[3:2]);
    tg = a[31:4];
    w  = -1;
    for (int k = 0; k < 2; k++) if (mv[k][s] && mt[k][s] == tg) w = k;
    eh = (w >= 0);
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0;
    got_hit = ready;
    chk(ready == eh, "R7 hit versus miss by replacement", {31'b0, ready}, {31'b0, eh});
    if (eh) begin
      exp = md[w][s];
      chk(hit && !miss, "R5 hit strobe", {30'b0, hit, miss}, 32'h2);
      chk(!mem_req, "R5 no memory request on hit", {31'b0, mem_req}, 32'h0);
      chk(rdata == exp, "R1 R2 R3 hit data", rdata, exp);
      mlru[s] = (w == 0);
    end else begin
      exp = mem_fn(a[31:2]);
      chk(mem_req, "R6 memory request", {31'b0, mem_req}, 32'h1);
      chk(mem_addr == a[31:2], "R6 memory address", {2'b0, mem_addr}, {2'b0, a[31:2]});
      for (int c = 0; c < lat; c++) begin
        if (stray && c == 0) begin
          req = 1'b1; addr = a ^ 32'h0000_0050;
        end
        @(negedge clk);
        req = 1'b0; addr = a;
        chk(mem_req && mem_addr == a[31:2] && !ready, "R8 R6 fill held",
            {2'b0, mem_addr}, {2'b0, a[31:2]});
      end
      mem_ready = 1'b1; mem_rdata = exp;
      @(negedge clk);
      mem_ready = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      chk(ready && miss && !hit, "R6 miss strobe", {29'b0, ready, miss, hit}, 32'h6);
      chk(rdata == exp, "R6 R1 fill data", rdata, exp);
      v = !mv[0][s] ? 0 : (!mv[1][s] ? 1 : int'(mlru[s]));
      mv[v][s] = 1; mt[v][s] = tg; md[v][s] = exp;
      mlru[s] = (v == 0);
    end
    @(negedge clk);
    chk(!ready && !mem_req, "R10 R8 single strobe", {30'b0, ready, mem_req}, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit h;
    logic [31:0] lcg;
    clear_model();
    repeat (3) @(negedge clk);
    chk(!ready && !mem_req, "R9 reset state", {30'b0, ready, mem_req}, 32'h0);
    rst_ni = 1'b1;

    // directed: three tags in set 1, hit on first between fills
    do_access(32'h0000_0004, 2, 0, h); chk(!h, "R7 first fill", {31'b0, h}, 0);
    do_access(32'h0000_0024, 1, 0, h); chk(!h, "R7 second fill", {31'b0, h}, 0);
    do_access(32'h0000_0005, 1, 0, h); chk(h, "R1 R4 rehit way 0", {31'b0, h}, 1);
    do_access(32'h0000_0054, 3, 1, h); chk(!h, "R7 evict lru", {31'b0, h}, 0);
    do_access(32'h0000_0007, 1, 0, h); chk(h, "R4 way 0 kept", {31'b0, h}, 1);
    do_access(32'h0000_0024, 1, 0, h); chk(!h, "R4 way 1 evicted", {31'b0, h}, 0);

    do_reset();
    do_access(32'h0000_0054, 1, 0, h); chk(!h, "R9 valid cleared", {31'b0, h}, 0);

    lcg = 32'h1357_9BDF;
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = {28'hA5A_0000 ^ 28'(lcg[25:24]), lcg[17:16], lcg[9:8]};
      do_access(a, 1 + (n % 3), lcg[30], h);
    end

    do_reset();
    for (int s = 0; s < 4; s++) begin
      do_access({28'h0000_001, 2'(s), 2'b00}, 1, 0, h);
      chk(!h, "R9 R7 empty after reset", {31'b0, h}, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule